// File: doc/BRIEF.md
# Posted Register Write Bridge

This block is the bus-facing register front end of a peripheral whose working registers are clocked by a separate, slower and unrelated functional clock. Ten of its registers must reach the functional domain. Each of them has a bus-side shadow, a toggle handshake that carries the value across, and a write-pending flag. The flag rises when a write is accepted and falls once the acknowledgement has come back through a synchroniser. The flags can be read together in a single pending register. Registers that do not cross the boundary, such as configuration, interrupt status and enables, take a write at once.

The bridge has two access modes. In posted mode, which is the reset default, a write to a crossing register completes in the same cycle. A second write to that register while its flag is still up is discarded, and a read of it while the flag is up returns an error response. In non-posted mode, the bus ready signal stays low until the value has landed, so software never sees a flag set. A soft reset, requested through the interface control register, first lets any transfers in flight finish. It then clears the functional-domain copies through its own handshake and restores every bus-side register to its default. A status bit reports when the soft reset is done.

Top module: `posted_wr_bridge`

## Requirements
- R1: A posted-mode write to a crossing register is accepted with bus_ready high in the cycle it is presented. From the next cycle its bit in the pending register (address 0x34) reads 1. The bit order, low to high, is: 0x24 (bit 0), 0x28 (bit 1), 0x2C (bit 2), 0x30 (bit 3), 0x38 (bit 4), and 0x48, 0x4C, 0x50, 0x54, 0x58 (bits 5 to 9).
- R2: The pending bit of a crossing register returns to 0 only after the written value appears on that register's slice of f_reg_q (bits i*DW upward for bit i). A read of the register then returns the value with bus_err low.
- R3: In posted mode, a write to a crossing register whose pending bit is 1 is discarded. Both the read-back value and the functional copy keep the earlier value.
- R4: In posted mode, a read of a crossing register whose pending bit is 1 completes with bus_ready and bus_err both high. A read of another crossing register that has no write pending completes with bus_err low.
- R5: In non-posted mode, a write to a crossing register holds bus_ready low for at least one cycle and completes only once the value is on f_reg_q. While the bridge is in non-posted mode, the pending register reads 0.
- R6: In non-posted mode, a read of a crossing register whose earlier write is still in flight holds bus_ready low until the write lands. It then returns the landed value with bus_err low.
- R7: The immediate registers at 0x10, 0x18, 0x1C and 0x20 hold a full DW-bit value. A write is visible on the next read, and it never sets a pending bit.
- R8: The interface control register is at 0x40. Bit 2 selects posted mode (1 = posted) and is 1 after the hardware reset. A write with bit 1 clear loads bit 2 from the written data. Bit 1 reads 1 while a soft reset is in progress.
- R9: Writing 1 to bit 1 of 0x40 starts a soft reset. While it runs, bit 0 of the system status register (0x14) reads 0, and it reads 1 when the soft reset is done. At completion the crossing and immediate registers read 0, every f_reg_q slice is 0, posted mode is selected and the pending register reads 0.
- R10: While a soft reset is in progress, every bus write completes without stalling and has no effect.
- R11: The identification register at 0x00 reads the ID_VALUE parameter, and system status bit 0 reads 1 after the hardware reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bclk | input | 1 | Bus clock |
| brst_n | input | 1 | Synchronous active-low reset, bus domain |
| bus_sel | input | 1 | Transfer request; held until bus_ready is high |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte address of the register |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Read data, valid while bus_sel and bus_ready are high |
| bus_ready | output | 1 | Transfer completes at the clock edge where this is high |
| bus_err | output | 1 | Error response for a posted read of a pending register |
| fclk | input | 1 | Functional clock, unrelated to bclk |
| frst_n | input | 1 | Synchronous active-low reset, functional domain |
| f_reg_q | output | 10*DW | Functional-domain copies of the crossing registers |
| f_reg_upd | output | 10 | One-cycle fclk pulse when a copy takes a new value |

## Verification
The bench builds the bridge with DW = 16 and SYNC_STAGES = 3, and clocks the functional side at a period unrelated to the bus clock. The deeper synchroniser widens each pending window to more than a dozen bus cycles. That makes a discarded write, an error read and a non-posted stall land deterministically inside the window. It also lets the bench sweep every crossing register and every immediate register in both modes, with arithmetically derived data patterns. The soft-reset sequence is exercised with both ignored writes and read-backs taken while the reset is still in its handshake.

// File: rtl/pwb_pkg.sv
// Package: address map, decode helpers and shared types for the posted
// register write bridge. Offsets are fixed because software decodes them
// and the pending-bit order follows the crossing-register order.
package pwb_pkg;

    localparam int BUS_AW = 8;
    localparam int NSYNC  = 10;
    localparam int NIMM   = 4;
    localparam int SIDX_W = $clog2(NSYNC);
    localparam int IIDX_W = $clog2(NIMM);

    localparam logic [BUS_AW-1:0] A_ID    = 8'h00;
    localparam logic [BUS_AW-1:0] A_SYSST = 8'h14;
    localparam logic [BUS_AW-1:0] A_PEND  = 8'h34;
    localparam logic [BUS_AW-1:0] A_IFCTL = 8'h40;

    typedef struct packed {
        logic              hit;
        logic [SIDX_W-1:0] idx;
    } sync_sel_t;

    typedef struct packed {
        logic              hit;
        logic [IIDX_W-1:0] idx;
    } imm_sel_t;

    typedef enum logic [1:0] {
        RS_IDLE  = 2'd0,
        RS_DRAIN = 2'd1,
        RS_HAND  = 2'd2
    } rst_state_e;

    // Address of crossing register i (i is also its pending-bit position).
    function automatic logic [BUS_AW-1:0] sync_addr(input int i);
        case (i)
            0:       return 8'h24;
            1:       return 8'h28;
            2:       return 8'h2C;
            3:       return 8'h30;
            4:       return 8'h38;
            default: return BUS_AW'(32'h48 + 4 * (i - 5));
        endcase
    endfunction

    // Address of immediate register i.
    function automatic logic [BUS_AW-1:0] imm_addr(input int i);
        case (i)
            0:       return 8'h10;
            1:       return 8'h18;
            2:       return 8'h1C;
            default: return 8'h20;
        endcase
    endfunction

    function automatic sync_sel_t decode_sync(input logic [BUS_AW-1:0] a);
        sync_sel_t r;
        r = '0;
        for (int i = 0; i < NSYNC; i++)
            if (a == sync_addr(i)) begin
                r.hit = 1'b1;
                r.idx = i[SIDX_W-1:0];
            end
        return r;
    endfunction

    function automatic imm_sel_t decode_imm(input logic [BUS_AW-1:0] a);
        imm_sel_t r;
        r = '0;
        for (int i = 0; i < NIMM; i++)
            if (a == imm_addr(i)) begin
                r.hit = 1'b1;
                r.idx = i[IIDX_W-1:0];
            end
        return r;
    endfunction

endpackage

// File: rtl/pwb_sync.sv
// Multi-flop synchroniser for a single level or toggle signal.
// Assumes: d changes at most once per several destination clocks
// (toggle handshake), STAGES >= 2.
module pwb_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] ff;

    // Shift the asynchronous input through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) ff <= '0;
        else        ff <= {ff[STAGES-2:0], d};
    end

    assign q = ff[STAGES-1];
endmodule

// File: rtl/pwb_slot.sv
// One crossing register: bus-side shadow and request toggle, synchronised
// acknowledge, write-pending flag, and the functional-domain copy.
// Assumes: launch is only raised while pend is low, and clr (bus) and
// fclr (functional) are only raised when no transfer is in flight.
module pwb_slot #(
    parameter int W      = 32,
    parameter int STAGES = 2
) (
    input  logic         bclk,
    input  logic         brst_n,
    input  logic         launch,
    input  logic [W-1:0] wdata,
    input  logic         clr,
    output logic         pend,
    output logic [W-1:0] shadow,
    input  logic         fclk,
    input  logic         frst_n,
    input  logic         fclr,
    output logic [W-1:0] fq,
    output logic         fupd
);
    logic req_q, ack_s;
    logic req_s, ack_q;

    // Bus side: latch the value and flip the request toggle on launch.
    always_ff @(posedge bclk) begin
        if (!brst_n) begin
            req_q  <= 1'b0;
            shadow <= '0;
        end else if (clr) begin
            shadow <= '0;
        end else if (launch) begin
            req_q  <= ~req_q;
            shadow <= wdata;
        end
    end

    pwb_sync #(.STAGES(STAGES)) i_ack_sync (
        .clk(bclk), .rst_n(brst_n), .d(ack_q), .q(ack_s));

    assign pend = req_q ^ ack_s;

    pwb_sync #(.STAGES(STAGES)) i_req_sync (
        .clk(fclk), .rst_n(frst_n), .d(req_q), .q(req_s));

    assign fupd = req_s ^ ack_q;

    // Functional side: capture the stable shadow and return the toggle.
    always_ff @(posedge fclk) begin
        if (!frst_n) begin
            ack_q <= 1'b0;
            fq    <= '0;
        end else begin
            if (fupd) begin
                ack_q <= req_s;
                fq    <= shadow;
            end else if (fclr) begin
                fq    <= '0;
            end
        end
    end

    // R1: an accepted write raises the pending flag on the next edge.
    a_r1_pend_after_launch: assert property (@(posedge bclk) disable iff (!brst_n)
        launch |=> pend);

    // R3: the bus side never launches over a transfer still in flight.
    a_r3_no_launch_when_pending: assert property (@(posedge bclk) disable iff (!brst_n)
        launch |-> !pend);
endmodule

// File: rtl/posted_wr_bridge.sv
// Posted register write bridge: bus decode, posted / non-posted write
// control for ten crossing registers, immediate registers, write-pending
// register, interface control and soft reset with completion status.
// Assumes: the bus holds sel/wr/addr/wdata stable until bus_ready is high;
// DW >= 16; bclk and fclk are unrelated.
module posted_wr_bridge
    import pwb_pkg::*;
#(
    parameter int          DW          = 32,
    parameter int          SYNC_STAGES = 2,
    parameter logic [DW-1:0] ID_VALUE  = DW'(32'h5042_0001)
) (
    input  logic                  bclk,
    input  logic                  brst_n,
    input  logic                  bus_sel,
    input  logic                  bus_wr,
    input  logic [BUS_AW-1:0]     bus_addr,
    input  logic [DW-1:0]         bus_wdata,
    output logic [DW-1:0]         bus_rdata,
    output logic                  bus_ready,
    output logic                  bus_err,
    input  logic                  fclk,
    input  logic                  frst_n,
    output logic [NSYNC*DW-1:0]   f_reg_q,
    output logic [NSYNC-1:0]      f_reg_upd
);
    sync_sel_t   ss;
    imm_sel_t    is;
    logic [NSYNC-1:0] pend, launch;
    logic [DW-1:0]    shadow [NSYNC];
    logic [DW-1:0]    imm_q  [NIMM];
    logic        posted_q, np_wait_q, busy, tgt_pend, wr_go, soft_clr;
    logic        ifctl_wr, rst_req_q, rst_ack_s, rst_pend;
    logic        f_rr, f_ra_q, f_clr;
    rst_state_e  st_q;

    assign ss       = decode_sync(bus_addr);
    assign is       = decode_imm(bus_addr);
    assign busy     = (st_q != RS_IDLE);
    assign tgt_pend = ss.hit && pend[ss.idx];
    assign wr_go    = bus_sel && bus_wr && !busy;
    assign ifctl_wr = wr_go && (bus_addr == A_IFCTL);
    assign soft_clr = (st_q == RS_HAND) && !rst_pend;

    // Transfer control: ready, error and per-register launch.
    always_comb begin
        bus_ready = 1'b1;
        bus_err   = 1'b0;
        launch    = '0;
        if (bus_sel && ss.hit && !busy) begin
            if (bus_wr) begin
                if (!posted_q) begin
                    bus_ready = np_wait_q && !tgt_pend;
                    if (!np_wait_q && !tgt_pend) launch[ss.idx] = 1'b1;
                end else if (!tgt_pend) begin
                    launch[ss.idx] = 1'b1;
                end
            end else if (tgt_pend) begin
                if (posted_q) bus_err   = 1'b1;
                else          bus_ready = 1'b0;
            end
        end
    end

    // Non-posted write tracking: set on launch, cleared at completion.
    always_ff @(posedge bclk) begin
        if (!brst_n || soft_clr)          np_wait_q <= 1'b0;
        else if (|launch && !posted_q)    np_wait_q <= 1'b1;
        else if (bus_sel && bus_wr && ss.hit && bus_ready) np_wait_q <= 1'b0;
    end

    // Access mode: posted by default, loaded from interface control bit 2.
    always_ff @(posedge bclk) begin
        if (!brst_n || soft_clr)           posted_q <= 1'b1;
        else if (ifctl_wr && !bus_wdata[1]) posted_q <= bus_wdata[2];
    end

    // Immediate registers: written at once, cleared by any reset.
    always_ff @(posedge bclk) begin
        if (!brst_n || soft_clr) begin
            for (int i = 0; i < NIMM; i++) imm_q[i] <= '0;
        end else if (wr_go && is.hit) begin
            imm_q[is.idx] <= bus_wdata;
        end
    end

    // Soft reset sequencer: drain in-flight writes, clear far side, restore.
    always_ff @(posedge bclk) begin
        if (!brst_n) begin
            st_q      <= RS_IDLE;
            rst_req_q <= 1'b0;
        end else begin
            case (st_q)
                RS_IDLE:  if (ifctl_wr && bus_wdata[1]) st_q <= RS_DRAIN;
                RS_DRAIN: if (pend == '0) begin
                              rst_req_q <= ~rst_req_q;
                              st_q      <= RS_HAND;
                          end
                RS_HAND:  if (!rst_pend) st_q <= RS_IDLE;
                default:  st_q <= RS_IDLE;
            endcase
        end
    end

    pwb_sync #(.STAGES(SYNC_STAGES)) i_rst_ack_sync (
        .clk(bclk), .rst_n(brst_n), .d(f_ra_q), .q(rst_ack_s));

    assign rst_pend = rst_req_q ^ rst_ack_s;

    pwb_sync #(.STAGES(SYNC_STAGES)) i_rst_req_sync (
        .clk(fclk), .rst_n(frst_n), .d(rst_req_q), .q(f_rr));

    assign f_clr = f_rr ^ f_ra_q;

    // Functional side of the soft-reset handshake: return the toggle.
    always_ff @(posedge fclk) begin
        if (!frst_n)    f_ra_q <= 1'b0;
        else if (f_clr) f_ra_q <= f_rr;
    end

    for (genvar g = 0; g < NSYNC; g++) begin : g_slot
        pwb_slot #(.W(DW), .STAGES(SYNC_STAGES)) i_slot (
            .bclk   (bclk),
            .brst_n (brst_n),
            .launch (launch[g]),
            .wdata  (bus_wdata),
            .clr    (soft_clr),
            .pend   (pend[g]),
            .shadow (shadow[g]),
            .fclk   (fclk),
            .frst_n (frst_n),
            .fclr   (f_clr),
            .fq     (f_reg_q[g*DW +: DW]),
            .fupd   (f_reg_upd[g])
        );
    end

    // Read data multiplexer.
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            A_ID:    bus_rdata = ID_VALUE;
            A_SYSST: bus_rdata[0] = !busy;
            A_PEND:  bus_rdata[NSYNC-1:0] = posted_q ? pend : '0;
            A_IFCTL: bus_rdata[2:0] = {posted_q, busy, 1'b0};
            default: begin
                if (ss.hit)      bus_rdata = shadow[ss.idx];
                else if (is.hit) bus_rdata = imm_q[is.idx];
            end
        endcase
    end

    // R4: an error response only in posted mode, and never with a stall.
    a_r4_err_posted_only: assert property (@(posedge bclk) disable iff (!brst_n)
        bus_err |-> (posted_q && bus_ready && !bus_wr));

    // R9: when the soft reset completes, nothing is left pending and posted mode is back.
    a_r9_clean_after_soft_reset: assert property (@(posedge bclk) disable iff (!brst_n)
        soft_clr |=> (pend == '0) && posted_q && !busy);

    // R9: the clearing handshake runs only after all crossings have drained.
    a_r9_drained_during_handshake: assert property (@(posedge bclk) disable iff (!brst_n)
        (st_q == RS_HAND) |-> (pend == '0));

    // R10: no crossing register is launched while a soft reset runs.
    a_r10_no_launch_in_reset: assert property (@(posedge bclk) disable iff (!brst_n)
        busy |-> (launch == '0));

    // R5: a non-posted write completes only after its crossing has landed.
    a_r5_np_write_landed: assert property (@(posedge bclk) disable iff (!brst_n)
        (bus_sel && bus_wr && ss.hit && !posted_q && !busy && bus_ready) |-> $past(|pend) || !tgt_pend);
endmodule

// File: tb/test_posted_wr_bridge.sv
module test_posted_wr_bridge;
    localparam int DW = 16;
    localparam int NS = 10;
    localparam logic [DW-1:0] IDV = 16'hA5C3;

    logic bclk = 0, fclk = 0, brst_n = 0, frst_n = 0;
    logic bus_sel = 0, bus_wr = 0;
    logic [7:0] bus_addr = 0;
    logic [DW-1:0] bus_wdata = 0, bus_rdata;
    logic bus_ready, bus_err;
    logic [NS*DW-1:0] f_reg_q;
    logic [NS-1:0] f_reg_upd;

    int n_tests = 0, n_fail = 0;
    bit finished = 0;

    always #2.5 bclk = ~bclk;
    always #8.5 fclk = ~fclk;

    posted_wr_bridge #(.DW(DW), .SYNC_STAGES(3), .ID_VALUE(IDV)) i_posted_wr_bridge (
        .bclk(bclk), .brst_n(brst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_ready(bus_ready), .bus_err(bus_err), .fclk(fclk), .frst_n(frst_n),
        .f_reg_q(f_reg_q), .f_reg_upd(f_reg_upd));

    function automatic logic [7:0] saddr(input int i);
        case (i)
            0: return 8'h24; 1: return 8'h28; 2: return 8'h2C;
            3: return 8'h30; 4: return 8'h38;
            default: return 8'(8'h48 + 4 * (i - 5));
        endcase
    endfunction

    function automatic logic [7:0] iaddr(input int i);
        case (i)
            0: return 8'h10; 1: return 8'h18; 2: return 8'h1C;
            default: return 8'h20;
        endcase
    endfunction

    task automatic chk(input bit ok, input string req, input int got, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
        end
    endtask

    // One bus transfer, started and ended on a falling edge.
    task automatic xfer(input bit wr, input logic [7:0] a, input logic [DW-1:0] d,
                        output logic [DW-1:0] rd, output bit er, output int stall);
        bus_sel = 1; bus_wr = wr; bus_addr = a; bus_wdata = d; stall = 0;
        #1;
        while (!bus_ready && stall < 1000) begin
            @(negedge bclk); #1; stall++;
        end
        rd = bus_rdata; er = bus_err;
        @(posedge bclk); @(negedge bclk);
        bus_sel = 0; bus_wr = 0;
    endtask

    task automatic wr(input logic [7:0] a, input logic [DW-1:0] d);
        logic [DW-1:0] rd; bit er; int st;
        xfer(1, a, d, rd, er, st);
    endtask

    task automatic rd(input logic [7:0] a, output logic [DW-1:0] v);
        bit er; int st;
        xfer(0, a, '0, v, er, st);
    endtask

    task automatic wait_idle();
        logic [DW-1:0] v;
        for (int k = 0; k < 300; k++) begin
            rd(8'h34, v);
            if (v == 0) break;
        end
    endtask

    initial begin
        #500000;
        if (!finished) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: got 0x0 expected 0x1");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [DW-1:0] v, v2; bit er; int st;
        repeat (4) @(negedge fclk);
        brst_n = 1; frst_n = 1;
        @(negedge bclk);

        // R11 / R8: reset state
        rd(8'h00, v); chk(v == IDV, "R11 id", v, IDV);
        rd(8'h14, v); chk(v[0] == 1, "R11 sysstat done", v, 1);
        rd(8'h40, v); chk(v[2:0] == 3'b100, "R8 ifctl default", v, 4);
        rd(8'h34, v); chk(v == 0, "R1 pend reset", v, 0);

        // R1 / R2: posted sweep over every crossing register
        for (int i = 0; i < NS; i++) begin
            logic [DW-1:0] pat;
            pat = DW'((i * 16'h1357 + 16'h0A1) ^ (i << 9));
            xfer(1, saddr(i), pat, v, er, st);
            chk(st == 0, "R1 posted no stall", st, 0);
            rd(8'h34, v);
            chk(v == (16'h1 << i), "R1 pend bit", v, 16'h1 << i);
            wait_idle();
            chk(f_reg_q[i*DW +: DW] == pat, "R2 landed", f_reg_q[i*DW +: DW], pat);
            xfer(0, saddr(i), '0, v, er, st);
            chk(v == pat && !er, "R2 readback", v, pat);
        end

        // R3 / R4: drop and error inside the pending window
        wr(8'h2C, 16'h1111);
        wr(8'h2C, 16'h2222);
        xfer(0, 8'h2C, '0, v, er, st);
        chk(er == 1 && st == 0, "R4 err on pending read", er, 1);
        xfer(0, 8'h38, '0, v, er, st);
        chk(er == 0, "R4 no err other reg", er, 0);
        wait_idle();
        rd(8'h2C, v);
        chk(v == 16'h1111, "R3 dropped write readback", v, 16'h1111);
        chk(f_reg_q[2*DW +: DW] == 16'h1111, "R3 dropped write far side", f_reg_q[2*DW +: DW], 16'h1111);

        // R7: immediate registers
        for (int i = 0; i < 4; i++) wr(iaddr(i), DW'(16'hC00 + i * 16'h0F1 + (i << 14)));
        rd(8'h34, v); chk(v == 0, "R7 no pending", v, 0);
        for (int i = 0; i < 4; i++) begin
            rd(iaddr(i), v);
            chk(v == DW'(16'hC00 + i * 16'h0F1 + (i << 14)), "R7 imm readback", v,
                DW'(16'hC00 + i * 16'h0F1 + (i << 14)));
        end

        // R6 / R5: in-flight posted write, then switch to non-posted
        wr(8'h30, 16'hBEEF);
        wr(8'h40, 16'h0000);
        rd(8'h40, v); chk(v[2] == 0, "R8 posted cleared", v, 0);
        rd(8'h34, v); chk(v == 0, "R5 pend reads zero non-posted", v, 0);
        xfer(0, 8'h30, '0, v, er, st);
        chk(st > 0 && v == 16'hBEEF && !er, "R6 np read stall", st, 1);
        for (int i = 0; i < NS; i++) begin
            logic [DW-1:0] pat;
            pat = DW'(16'hFFFF - i * 16'h0303);
            xfer(1, saddr(i), pat, v, er, st);
            chk(st > 0, "R5 np write stalls", st, 1);
            chk(f_reg_q[i*DW +: DW] == pat, "R5 np landed at completion", f_reg_q[i*DW +: DW], pat);
        end

        // R9 / R10: soft reset
        wr(8'h40, 16'h0004);
        wr(8'h10, 16'h7777);
        wr(8'h40, 16'h0002);
        rd(8'h14, v); chk(v[0] == 0, "R9 sysstat busy", v, 0);
        xfer(1, 8'h10, 16'h5555, v2, er, st);
        chk(st == 0, "R10 write no stall", st, 0);
        xfer(1, 8'h24, 16'h4444, v2, er, st);
        rd(8'h10, v); chk(v == 16'h7777, "R10 imm write ignored", v, 16'h7777);
        rd(8'h40, v); chk(v[1] == 1, "R8 busy bit", v, 2);
        for (int k = 0; k < 300; k++) begin
            rd(8'h14, v);
            if (v[0]) break;
        end
        chk(v[0] == 1, "R9 sysstat done", v, 1);
        rd(8'h10, v); chk(v == 0, "R9 imm cleared", v, 0);
        rd(8'h24, v); chk(v == 0, "R9 sync cleared", v, 0);
        rd(8'h40, v); chk(v[2:0] == 3'b100, "R9 posted restored", v, 4);
        rd(8'h34, v); chk(v == 0, "R9 pend cleared", v, 0);
        chk(f_reg_q == '0, "R9 far side cleared", 0, 0);

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule